// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes written by a processor into asynchronous serial frames on a single output line. A byte written through the write port lands in a one-entry holding register. On the next bit-rate strobe while the shifter is free, the byte moves into a shift register as a complete frame image. The frame is a low start bit, then 7 or 8 data bits sent least significant first, then an optional extra bit, then one or two high stop bits. The extra bit is either a parity bit or, in multiprocessor mode, a flag bit whose value comes from an input.

Six format inputs choose the frame shape. Three of them select the data width, parity enable and stop count, which gives eight plain formats. A multiprocessor enable replaces parity with the programmed flag bit. A parity-sense input picks even or odd parity. The format is sampled when a frame starts, so changing the inputs during a frame does not change that frame.

A holding-empty flag tells the processor when it may write the next byte. An active-low clear-to-send input does not stop transmission. While that input is high, it forces the flag low. Baud-rate generation, reception and interrupt routing belong to other blocks.

Top module: `serial_frame_tx`

## Requirements
- R1: Out of reset the line `txOut` is 1, and `txEmpty` is 1 while `ctsN` is 0.
- R2: `fmtWide`=1 sends 8 data bits and `fmtWide`=0 sends 7. Data bits are sent LSB first, right after the start bit. With 7 bits, bit 7 of the written byte is neither sent nor counted in parity.
- R3: With `fmtParity`=1 and `mpEnable`=0, one parity bit follows the data. With `parityOdd`=0 it makes the count of ones over the data and parity even; with `parityOdd`=1 it makes that count odd.
- R4: `fmtTwoStop`=0 ends the frame with one high stop bit and `fmtTwoStop`=1 with two. The last bit of every frame is 1.
- R5: With `mpEnable`=1, the bit after the data equals `mpBitValue` and no parity bit is sent, whatever `fmtParity` is.
- R6: A frame starts only on a cycle with `bitTick`=1 while a byte is held and the shifter is free. The start bit is 0, and `txOut` changes only on the cycle after a `bitTick`. Each bit lasts one strobe period, and a strobe with no byte held leaves the line at 1.
- R7: A write (`wrEn`=1) makes `txEmpty` 0 on the next cycle. `txEmpty` returns to 1 when the byte moves into the shifter. While `ctsN` is 1, `txEmpty` is 0.
- R8: A byte written during a frame starts its start bit on the strobe that would end the last stop bit, with no idle bit in between.
- R9: The format inputs are sampled on the strobe that starts a frame; changing them during the frame does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the data byte |
| wrData | input | 8 | Data byte to send |
| fmtWide | input | 1 | 1: 8 data bits, 0: 7 data bits |
| fmtParity | input | 1 | 1: parity bit enabled |
| fmtTwoStop | input | 1 | 1: two stop bits |
| mpEnable | input | 1 | 1: multiprocessor flag bit instead of parity |
| mpBitValue | input | 1 | Value of the multiprocessor flag bit |
| parityOdd | input | 1 | 0: even parity, 1: odd parity |
| bitTick | input | 1 | One-cycle bit-rate strobe |
| ctsN | input | 1 | Clear to send, active low |
| txOut | output | 1 | Serial line, idles high |
| txEmpty | output | 1 | Holding register empty and clear to send |

## Verification
The assertions check timing on every cycle. The line moves only right after a strobe. A frame start always shows a low bit next. Every frame ends on a high bit, and on a strobe. A write always clears the empty flag. Whether the bits in a frame are correct can only be shown by the bench's scenarios. These cover the data width, the masking of bit 7 out of parity, even and odd parity, stop counts, the multiprocessor flag, sampling of the format at frame start, back-to-back frames and the clear-to-send masking.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  // Strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic captureByte;  // latch the written byte in the holding register
    logic startFrame;   // build the frame image into the shifter
    logic advanceBit;   // move to the next bit of the current frame
  } txStrobe_t;

  // Format inputs as one bundle
  typedef struct packed {
    logic wide;
    logic parityEn;
    logic twoStop;
    logic mpEn;
    logic mpBit;
    logic parityOdd;
  } txFormat_t;

endpackage

// File: rtl/sftx_ctrl.sv
module sftx_ctrl
  import sftx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             bitTick,
  input  logic             ctsN,
  input  logic [CNT_W-1:0] frameLen,
  output txStrobe_t        strobe,
  output logic             busy,
  output logic             txEmpty
);

  logic             holdValid;
  logic [CNT_W-1:0] bitsLeft;
  logic             lastBit;

  assign lastBit = busy && (bitsLeft == CNT_W'(1));

  always_comb begin
    strobe.captureByte = wrEn;
    strobe.startFrame  = bitTick && holdValid && (!busy || lastBit);
    strobe.advanceBit  = bitTick && busy && !strobe.startFrame;
  end

  // Holding register occupancy: a write wins over a transfer in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
    end else if (strobe.captureByte) begin
      holdValid <= 1'b1;
    end else if (strobe.startFrame) begin
      holdValid <= 1'b0;
    end
  end

  // Bit counter of the frame in flight
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      bitsLeft <= '0;
    end else if (strobe.startFrame) begin
      busy     <= 1'b1;
      bitsLeft <= frameLen;
    end else if (strobe.advanceBit) begin
      bitsLeft <= bitsLeft - CNT_W'(1);
      if (lastBit) begin
        busy <= 1'b0;
      end
    end
  end

  assign txEmpty = !holdValid && !ctsN;

  // R7
  write_clears_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !txEmpty);

  // R6
  busy_holds_without_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !bitTick) |=> busy);

  // R6
  frame_ends_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(bitTick));

endmodule

// File: rtl/sftx_datapath.sv
module sftx_datapath
  import sftx_pkg::*;
#(
  parameter int MAX_DATA = 8,
  parameter int FRAME_W  = MAX_DATA + 4,
  parameter int CNT_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobe_t           strobe,
  input  logic [MAX_DATA-1:0] wrData,
  input  txFormat_t           fmtIn,
  input  logic                busy,
  output logic [CNT_W-1:0]    frameLen,
  output logic                txOut
);

  logic [MAX_DATA-1:0] holdData;
  logic [FRAME_W-1:0]  shiftReg;
  logic [FRAME_W-1:0]  frameImg;
  logic [MAX_DATA-1:0] maskedData;
  logic [CNT_W-1:0]    dataBits;
  logic                hasExtra;
  logic                extraVal;
  logic                parityBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
    end else if (strobe.captureByte) begin
      holdData <= wrData;
    end
  end

  // Frame image, bit 0 first on the line; unused upper bits stay high
  always_comb begin
    dataBits   = fmtIn.wide ? CNT_W'(MAX_DATA) : CNT_W'(MAX_DATA - 1);
    maskedData = holdData;
    if (!fmtIn.wide) begin
      maskedData[MAX_DATA-1] = 1'b0;
    end
    parityBit = (^maskedData) ^ fmtIn.parityOdd;
    hasExtra  = fmtIn.mpEn || fmtIn.parityEn;
    extraVal  = fmtIn.mpEn ? fmtIn.mpBit : parityBit;
    frameImg    = '1;
    frameImg[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < int'(dataBits)) begin
        frameImg[1 + i] = maskedData[i];
      end
    end
    if (hasExtra) begin
      frameImg[1 + int'(dataBits)] = extraVal;
    end
    frameLen = CNT_W'(2) + dataBits + CNT_W'(hasExtra) + CNT_W'(fmtIn.twoStop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
    end else if (strobe.startFrame) begin
      shiftReg <= frameImg;
    end else if (strobe.advanceBit) begin
      shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
    end
  end

  assign txOut = busy ? shiftReg[0] : 1'b1;

  // R6
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startFrame |=> !txOut);

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter int MAX_DATA = 8,
  localparam int FRAME_W = MAX_DATA + 4,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [MAX_DATA-1:0] wrData,
  input  logic                fmtWide,
  input  logic                fmtParity,
  input  logic                fmtTwoStop,
  input  logic                mpEnable,
  input  logic                mpBitValue,
  input  logic                parityOdd,
  input  logic                bitTick,
  input  logic                ctsN,
  output logic                txOut,
  output logic                txEmpty
);

  txStrobe_t        strobe;
  txFormat_t        fmtIn;
  logic             busy;
  logic [CNT_W-1:0] frameLen;

  always_comb begin
    fmtIn.wide      = fmtWide;
    fmtIn.parityEn  = fmtParity;
    fmtIn.twoStop   = fmtTwoStop;
    fmtIn.mpEn      = mpEnable;
    fmtIn.mpBit     = mpBitValue;
    fmtIn.parityOdd = parityOdd;
  end

  sftx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .bitTick  (bitTick),
    .ctsN     (ctsN),
    .frameLen (frameLen),
    .strobe   (strobe),
    .busy     (busy),
    .txEmpty  (txEmpty)
  );

  sftx_datapath #(.MAX_DATA(MAX_DATA), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .fmtIn    (fmtIn),
    .busy     (busy),
    .frameLen (frameLen),
    .txOut    (txOut)
  );

  // R4
  last_bit_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(txOut));

  // R6
  line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(bitTick) |-> $stable(txOut));

endmodule

// File: tb/serial_frame_tx_bench.sv
`timescale 1ns/1ps
module serial_frame_tx_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic fmtWide = 1'b1, fmtParity = 1'b0, fmtTwoStop = 1'b0;
  logic mpEnable = 1'b0, mpBitValue = 1'b0, parityOdd = 1'b0;
  logic bitTick = 1'b0;
  logic ctsN = 1'b0;
  logic txOut, txEmpty;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  serial_frame_tx u_serial_frame_tx (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .fmtWide(fmtWide), .fmtParity(fmtParity), .fmtTwoStop(fmtTwoStop),
    .mpEnable(mpEnable), .mpBitValue(mpBitValue), .parityOdd(parityOdd),
    .bitTick(bitTick), .ctsN(ctsN), .txOut(txOut), .txEmpty(txEmpty)
  );

  // Frame vectors: line bits listed LSB first (bit 0 = start bit)
  typedef struct packed {
    logic [7:0]  data;
    logic        wide, par, two, mp, mpb, odd;
    logic [11:0] expBits;
    logic [3:0]  expLen;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{8'h55, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h2AA, 4'd10}, // 8N1
    '{8'hC3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'h386, 4'd10}, // 7E1, bit7 masked
    '{8'h01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 12'hC02, 4'd12}, // 8O2
    '{8'h80, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'h700, 4'd11}, // 8E1
    '{8'h7F, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 12'h6FE, 4'd11}, // 7 MP=0 2 stop
    '{8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 12'h600, 4'd11}, // 8 MP=1 1 stop
    '{8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 12'h34A, 4'd10}  // 7N2
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic pulseTick();
    bitTick = 1'b1;
    @(negedge clk);
    bitTick = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] d);
    wrData = d;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setFmt(input vec_t v);
    fmtWide = v.wide; fmtParity = v.par; fmtTwoStop = v.two;
    mpEnable = v.mp; mpBitValue = v.mpb; parityOdd = v.odd;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) pulseTick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] got;
    vec_t v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txOut === 1'b1, "R1 reset line", txOut, 1);
    check(txEmpty === 1'b1, "R1 reset empty", txEmpty, 1);

    // R6: a strobe with nothing held leaves the line idle
    pulseTick();
    check(txOut === 1'b1, "R6 tick with no byte", txOut, 1);

    // R7: clear-to-send high masks the flag
    ctsN = 1'b1; #1;
    check(txEmpty === 1'b0, "R7 cts masks empty", txEmpty, 0);
    ctsN = 1'b0; #1;
    check(txEmpty === 1'b1, "R7 cts released", txEmpty, 1);

    // Frame table walk: R2 R3 R4 R5 R6 R7 R9
    for (int n = 0; n < NVEC; n++) begin
      v = VECS[n];
      setFmt(v);
      writeByte(v.data);
      check(txEmpty === 1'b0, "R7 write clears empty", txEmpty, 0);
      check(txOut === 1'b1, "R6 no start before tick", txOut, 1);
      pulseTick();
      check(txEmpty === 1'b1, "R7 empty after transfer", txEmpty, 1);
      // R9: scramble format inputs during the frame
      fmtWide = ~v.wide; fmtParity = ~v.par; fmtTwoStop = ~v.two;
      mpEnable = ~v.mp; mpBitValue = ~v.mpb; parityOdd = ~v.odd;
      got = '0;
      for (int i = 0; i < int'(v.expLen); i++) begin
        got[i] = txOut;
        @(negedge clk);
        check(txOut === got[i], "R6 bit held between ticks", txOut, got[i]);
        pulseTick();
      end
      check(got === v.expBits, $sformatf("R2 R3 R4 R5 R9 frame %0d", n), got, v.expBits);
      check(txOut === 1'b1, "R4 idle after stop", txOut, 1);
    end

    // R7: clear-to-send high during the transfer keeps the flag low
    setFmt(VECS[0]);
    ctsN = 1'b1;
    writeByte(8'h55);
    pulseTick();
    check(txEmpty === 1'b0, "R7 cts during transfer", txEmpty, 0);
    check(txOut === 1'b0, "R6 start bit with cts high", txOut, 0);
    ctsN = 1'b0; #1;
    check(txEmpty === 1'b1, "R7 flag after cts low", txEmpty, 1);
    ticks(10);
    check(txOut === 1'b1, "R4 idle after cts frame", txOut, 1);

    // R8: back-to-back frames
    writeByte(8'h55);
    pulseTick();
    writeByte(8'h0F);
    check(txEmpty === 1'b0, "R8 second byte held", txEmpty, 0);
    ticks(9);
    check(txOut === 1'b1, "R8 last stop of first frame", txOut, 1);
    check(txEmpty === 1'b0, "R8 still held at stop", txEmpty, 0);
    pulseTick();
    check(txOut === 1'b0, "R8 start bit follows stop", txOut, 0);
    check(txEmpty === 1'b1, "R8 empty after transfer", txEmpty, 1);
    pulseTick();
    check(txOut === 1'b1, "R8 first data bit", txOut, 1);
    ticks(9);
    check(txOut === 1'b1, "R8 idle after second frame", txOut, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule